// File: doc/BRIEF.md
# Host Interrupt Status and Mask Unit

This block collects single-cycle event pulses from the rest of a storage controller and latches each one into a bit of a 32-bit host interrupt status register. The host clears a latched bit by writing a one to it; writing a zero to a bit leaves that bit unchanged. A 32-bit enable register uses the same bit positions and selects which latched sources may reach the host. The block drives one level interrupt line. It also outputs a short message code that names one pending, enabled source, so that a message-based interrupt path can tell the host which source to service first.

The eleven source positions are as follows:
- Bit 0: firmware state change.
- Bit 1: completion posted.
- Bit 2: message from the device.
- Bits 5 to 8: queue-full events for queues 0 to 3.
- Bit 9: command FIFO overrun.
- Bit 10: bad expansion-ROM read.

Bits 3 and 4 are reserved. Bits 3, 4 and 11 to 31 can never become set.

The host reaches both registers through a plain address, write-enable, write-data and read-data port.

Top module: `irq_stat_unit`

## Requirements
- R1: After reset, the status register reads 0. The enable register reads 0x7E7, which sets bits 0-2 and 5-10. The interrupt line, the message-valid output and the message code are all 0.
- R2: An event pulse on a defined source bit sets that status bit at the next clock edge. The bit stays set until the host clears it.
- R3: A write to offset 0x20 clears every status bit whose write-data bit is 1. It leaves every bit whose write-data bit is 0 unchanged.
- R4: Status bits 3, 4 and 11-31 always read 0, whatever events or writes arrive. Enable bits 3, 4 and 11-31 also always read 0.
- R5: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R6: A write to offset 0x28 loads the enable register with the write data, limited to the defined bits. A read of offset 0x28 returns the enable register.
- R7: The interrupt line is registered. It is high one cycle after a cycle in which some status bit is both set and enabled, and low otherwise.
- R8: The message code is registered. Source bit n of bits 0-2 and 5-8 gives code n+4: 4, 5 and 6 for bits 0-2, and 9 to 12 for queues 0 to 3. While no coded source is pending and enabled, the message-valid output is 0 and the code is 0.
- R9: When several coded sources are pending and enabled, the code belongs to the lowest-numbered one.
- R10: Bits 9 and 10 have no message code. They raise the interrupt line but never the message-valid output.
- R11: Reads at any offset other than 0x20 and 0x28 return 0. Writes there change neither register.
- R12: Read data is registered. It shows the register contents as they stood before the clock edge that samples the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 11 | One-cycle event pulses, one per source bit position |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the offset in `addr` |
| irq_o | output | 1 | Level interrupt line |
| msg_valid_o | output | 1 | A coded source is pending and enabled |
| msg_code_o | output | 4 | Code of the lowest pending, enabled coded source |

## Verification
The assertions assume that writes only ever target offsets 0x20 and 0x28 or an unused offset. They also assume that `evt_i` may carry pulses on reserved positions 3 and 4, which the design must ignore. No other input assumption is made. The stimulus keeps to these conditions while still stressing the block. It sets each event bit with probability one in eight, including the reserved positions. Writes go mostly to the two valid offsets and sometimes to random other offsets. Write data is fully random, so clears, rewrites of the enable register and event-versus-clear collisions all occur. Directed sequences cover reset, reserved bits, the uncoded sources, priority and same-cycle set/clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int NUM_EVT  = 11;
  localparam int CODE_W   = 4;
  localparam logic [DATA_W-1:0] DEF_BITS = 32'h0000_07E7;
  localparam logic [DATA_W-1:0] RST_EN   = 32'h0000_07E7;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_EN   = 8'h28;

  // message code for a source position, 0 when the source has none
  function automatic logic [CODE_W-1:0] src_code(input int idx);
    if ((idx >= 0 && idx <= 2) || (idx >= 5 && idx <= 8))
      return CODE_W'(idx + 4);
    return '0;
  endfunction
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
  import irq_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int NE = NUM_EVT,
  parameter logic [W-1:0] DEF = DEF_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NE-1:0] evt_i,
  input  logic          clr_en,
  input  logic [W-1:0]  clr_bits,
  output logic [W-1:0]  stat_q
);
  localparam int LIVE = (NE < W) ? NE : W;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < LIVE && DEF[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (rst)
          stat_q[i] <= 1'b0;
        else if (evt_i[i])
          stat_q[i] <= 1'b1;
        else if (clr_en && clr_bits[i])
          stat_q[i] <= 1'b0;
      end
    end else begin : g_rsvd
      assign stat_q[i] = 1'b0;
    end
  end

  logic [W-1:0] evt_ext;
  always_comb begin
    evt_ext = '0;
    evt_ext[LIVE-1:0] = evt_i[LIVE-1:0];
  end

  // R2: a pulse on a defined bit is visible one edge later
  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    |(evt_ext & DEF) |=> ((stat_q & $past(evt_ext & DEF)) == $past(evt_ext & DEF)));

  // R3: a clear without an event removes the written bits
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (rst)
    (clr_en && (evt_ext == '0)) |=> ((stat_q & $past(clr_bits)) == '0));

  // R3: bits neither written nor hit keep their value
  a_r3_hold_others: assert property (@(posedge clk) disable iff (rst)
    (evt_ext == '0) |=> ((stat_q & ~$past(clr_en ? clr_bits : '0))
                         == ($past(stat_q) & ~$past(clr_en ? clr_bits : '0))));

  // R4: reserved positions never set
  a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    |evt_ext |=> ((stat_q & ~DEF) == '0));
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg
  import irq_pkg::*;
#(
  parameter int W = DATA_W,
  parameter logic [W-1:0] DEF = DEF_BITS,
  parameter logic [W-1:0] RST_VAL = RST_EN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)
      en_q <= RST_VAL & DEF;
    else if (ld_en)
      en_q <= ld_val & DEF;
  end

  // R11: the enable register only moves on its own write strobe
  a_r11_en_stable: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> (en_q == $past(en_q)));

  // R6: a load is read back masked to the defined bits
  a_r6_en_load: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (en_q == ($past(ld_val) & DEF)));
endmodule

// File: rtl/irq_src_encoder.sv
module irq_src_encoder
  import irq_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int NE = NUM_EVT,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  pend,
  output logic          irq_o,
  output logic          msg_valid_o,
  output logic [CW-1:0] msg_code_o
);
  localparam int LIVE = (NE < W) ? NE : W;

  logic          hit;
  logic [CW-1:0] code_n;

  always_comb begin
    hit    = 1'b0;
    code_n = '0;
    for (int i = LIVE - 1; i >= 0; i--) begin
      if (pend[i] && (src_code(i) != '0)) begin
        hit    = 1'b1;
        code_n = src_code(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o       <= 1'b0;
      msg_valid_o <= 1'b0;
      msg_code_o  <= '0;
    end else begin
      irq_o       <= |pend;
      msg_valid_o <= hit;
      msg_code_o  <= code_n;
    end
  end

  // R8: idle message outputs carry code 0
  a_r8_idle_code: assert property (@(posedge clk) disable iff (rst)
    !msg_valid_o |-> (msg_code_o == '0));

  // R8: a valid code lies in one of the two allowed ranges
  a_r8_code_range: assert property (@(posedge clk) disable iff (rst)
    msg_valid_o |-> ((msg_code_o >= 4 && msg_code_o <= 6) ||
                     (msg_code_o >= 9 && msg_code_o <= 12)));

  // R10: a message never appears without the interrupt line
  a_r10_msg_implies_irq: assert property (@(posedge clk) disable iff (rst)
    msg_valid_o |-> irq_o);
endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
  import irq_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NE = NUM_EVT,
  parameter int CW = CODE_W,
  parameter logic [AW-1:0] STAT_OFS = OFS_STAT,
  parameter logic [AW-1:0] EN_OFS   = OFS_EN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NE-1:0] evt_i,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          irq_o,
  output logic          msg_valid_o,
  output logic [CW-1:0] msg_code_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] en_q;
  logic         stat_wr;
  logic         en_wr;

  assign stat_wr = wr_en && (addr == STAT_OFS);
  assign en_wr   = wr_en && (addr == EN_OFS);

  irq_stat_bank #(.W(W), .NE(NE), .DEF(DEF_BITS)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt_i),
    .clr_en   (stat_wr),
    .clr_bits (wdata),
    .stat_q   (stat_q)
  );

  irq_en_reg #(.W(W), .DEF(DEF_BITS), .RST_VAL(RST_EN)) u_en (
    .clk    (clk),
    .rst    (rst),
    .ld_en  (en_wr),
    .ld_val (wdata),
    .en_q   (en_q)
  );

  irq_src_encoder #(.W(W), .NE(NE), .CW(CW)) u_enc (
    .clk         (clk),
    .rst         (rst),
    .pend        (stat_q & en_q),
    .irq_o       (irq_o),
    .msg_valid_o (msg_valid_o),
    .msg_code_o  (msg_code_o)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (addr == STAT_OFS)
      rdata <= stat_q;
    else if (addr == EN_OFS)
      rdata <= en_q;
    else
      rdata <= '0;
  end

  // R7: the interrupt line follows masked status with one register stage
  a_r7_irq_level: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == $past(|(stat_q & en_q))));

  // R11: unused offsets read as zero
  a_r11_stray_read: assert property (@(posedge clk) disable iff (rst)
    ((addr != STAT_OFS) && (addr != EN_OFS)) |=> (rdata == '0));

  // R12: read data reflects the pre-edge status
  a_r12_read_stat: assert property (@(posedge clk) disable iff (rst)
    (addr == STAT_OFS) |=> (rdata == $past(stat_q)));
endmodule

// File: tb/tb_irq_stat_unit.sv
module tb_irq_stat_unit;
  localparam int CLK_T = 10;
  localparam int W = 32;
  localparam int NE = 11;
  localparam logic [W-1:0] DEF = 32'h0000_07E7;

  logic          clk = 1'b0;
  logic          rst;
  logic [NE-1:0] evt_i;
  logic          wr_en;
  logic [7:0]    addr;
  logic [W-1:0]  wdata;
  logic [W-1:0]  rdata;
  logic          irq_o;
  logic          msg_valid_o;
  logic [3:0]    msg_code_o;

  int total = 0;
  int bad = 0;
  logic [W-1:0] m_st;
  logic [W-1:0] m_en;

  always #(CLK_T/2) clk = ~clk;

  irq_stat_unit dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
    .msg_valid_o(msg_valid_o), .msg_code_o(msg_code_o)
  );

  function automatic logic [3:0] exp_code(input logic [W-1:0] p);
    for (int i = 0; i < NE; i++)
      if (p[i] && ((i <= 2) || (i >= 5 && i <= 8))) return 4'(i + 4);
    return 4'd0;
  endfunction

  function automatic logic [W-1:0] exp_read(input logic [7:0] a,
                                            input logic [W-1:0] s,
                                            input logic [W-1:0] e);
    if (a == 8'h20) return s;
    if (a == 8'h28) return e;
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one clock: drive, advance, compare against the model, update model
  task automatic cycle(input logic [NE-1:0] e, input logic w,
                       input logic [7:0] a, input logic [W-1:0] d);
    logic [W-1:0] p;
    logic [W-1:0] rd_x;
    @(negedge clk);
    evt_i = e; wr_en = w; addr = a; wdata = d;
    p    = m_st & m_en;
    rd_x = exp_read(a, m_st, m_en);
    @(posedge clk);
    #1;
    chk("R7 irq", W'(irq_o), W'(|p));
    chk("R8 msg_valid", W'(msg_valid_o), W'(exp_code(p) != 4'd0));
    chk("R9 msg_code", W'(msg_code_o), W'(exp_code(p)));
    chk("R12 rdata", rdata, rd_x);
    if (w && a == 8'h20) m_st = m_st & ~d;
    m_st = (m_st | W'(e)) & DEF;
    if (w && a == 8'h28) m_en = d & DEF;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    evt_i = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    rst = 1'b1;
    m_st = '0; m_en = DEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 irq", W'(irq_o), '0);
    chk("R1 msg_valid", W'(msg_valid_o), '0);
    chk("R1 rdata", rdata, '0);
    cycle('0, 1'b0, 8'h20, '0);
    chk("R1 status", rdata, '0);
    cycle('0, 1'b0, 8'h28, '0);
    chk("R1 enable", rdata, 32'h7E7);
    // R4 reserved event positions ignored
    cycle(11'h018, 1'b0, 8'h20, '0);
    cycle('0, 1'b0, 8'h20, '0);
    chk("R4 rsvd status", rdata, '0);
    // R10 uncoded source raises irq only
    cycle(11'h200, 1'b0, 8'h00, '0);
    cycle('0, 1'b0, 8'h00, '0);
    chk("R10 irq", W'(irq_o), 32'd1);
    chk("R10 msg_valid", W'(msg_valid_o), '0);
    // R9 lowest pending coded source: bit5 beats bit8
    cycle(11'h120, 1'b0, 8'h00, '0);
    cycle('0, 1'b0, 8'h00, '0);
    chk("R9 code", W'(msg_code_o), 32'd9);
    chk("R2 status", m_st, 32'h320);
    // R5 event and clear collide
    cycle(11'h020, 1'b1, 8'h20, 32'h20);
    cycle('0, 1'b0, 8'h20, '0);
    chk("R5 collide", rdata, 32'h320);
    // R3 write one clears, zeros hold
    cycle('0, 1'b1, 8'h20, 32'h100);
    cycle('0, 1'b0, 8'h20, '0);
    chk("R3 w1c", rdata, 32'h220);
    // R6 enable write, masked to defined bits
    cycle('0, 1'b1, 8'h28, 32'hFFFF_FFFF);
    cycle('0, 1'b0, 8'h28, '0);
    chk("R6 en all", rdata, 32'h7E7);
    cycle('0, 1'b1, 8'h28, 32'h200);
    cycle('0, 1'b0, 8'h28, '0);
    chk("R6 en one", rdata, 32'h200);
    cycle('0, 1'b0, 8'h00, '0);
    chk("R8 masked code", W'(msg_valid_o), '0);
    chk("R7 masked irq", W'(irq_o), 32'd1);
    // R11 stray offset
    cycle('0, 1'b1, 8'h30, '0);
    cycle('0, 1'b0, 8'h30, '0);
    chk("R11 stray read", rdata, '0);
    cycle('0, 1'b0, 8'h28, '0);
    chk("R11 enable kept", rdata, 32'h200);
    // R7 clear everything, line drops
    cycle('0, 1'b1, 8'h20, 32'hFFFF_FFFF);
    cycle('0, 1'b0, 8'h00, '0);
    cycle('0, 1'b0, 8'h00, '0);
    chk("R7 irq low", W'(irq_o), '0);
    // random phase
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [NE-1:0] e;
      logic [7:0] a;
      int sel;
      for (int b = 0; b < NE; b++) e[b] = (($urandom % 8) == 0);
      sel = $urandom % 8;
      a = (sel < 4) ? 8'h20 : (sel < 7) ? 8'h28 : 8'($urandom);
      cycle(e, (($urandom % 4) == 0), a, $urandom);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule